// File: doc/BRIEF.md
# Addressed Serial Control Register Port

This block is a write-only serial control interface that feeds a small register file. A host shifts a 16-bit command word in on a serial clock, then raises a separate latch strobe to commit the word. The top four bits of the word choose a destination register. Two bits below them must be zero. The low ten bits are the value to store.

Nine destinations exist: six per-channel volume registers and three control words. The remaining seven address codes do nothing. The block does not interpret the control-word bits and offers no readback.

The serial clock, data and latch pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser. The block then detects the edges of the serial clock and of the latch strobe in the system clock domain, so the serial clock must run well below the system clock. Every register value sits on a flat output bus and can be wired straight to the logic it controls.

Top module: `ctl_serial_port`

## Requirements
- R1: A frame is 16 bits sent most significant bit first. Each bit is taken from the data pin at a rising edge of the serial clock pin.
- R2: On a committed frame, bits 15:12 select the register and bits 9:0 are its new value. Codes 0 to 5 select volume channels 0 to 5, which appear at `vol_o[10*i +: 10]`. Codes 6 to 8 select control words 0 to 2, which appear at `ctl_o[10*(code-6) +: 10]`. All other registers keep their values.
- R3: A committed frame in which bit 11 or bit 10 is 1 changes no register.
- R4: A committed frame whose address code is 9 to 15 changes no register.
- R5: After reset every volume register reads 0x3FF and every control word reads 0x000.
- R6: A rising edge of the latch pin commits the shifted word only if exactly 16 serial clock rising edges arrived since the previous latch edge or reset. Otherwise the word is dropped. In both cases the bit count restarts at zero.
- R7: A single commit changes at most one register.
- R8: Register outputs change only as a result of a latch rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdat_i | input | 1 | Serial data from host (asynchronous) |
| slat_i | input | 1 | Latch strobe from host (asynchronous) |
| vol_o | output | 60 | Six 10-bit volume values, channel 0 in bits 9:0 |
| ctl_o | output | 30 | Three 10-bit control words, word 0 in bits 9:0 |

## Verification
Assertions check four things on every cycle:
- The register file holds still unless a commit pulse arrives.
- Commits with a reserved bit set, or with an unused address, leave every register untouched.
- No commit alters more than one register.
- The bit counter returns to zero after each latch edge and stays within its saturation bound.

Only the bench's scenarios can show the behaviours that depend on values and ordering. These are the bit order and address decoding, the reset values, and the rejection of frames that are too short or too long. They also include recovery, where a good frame is accepted directly after a rejected one.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
    localparam int ADDR_W_DEF  = 4;
    localparam int RSV_W_DEF   = 2;
    localparam int DATA_W_DEF  = 10;
    localparam int NUM_VOL_DEF = 6;
    localparam int NUM_CTL_DEF = 3;
endpackage

// File: rtl/ctl_sync2.sv
module ctl_sync2 #(
    parameter int WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o = st_q.s2;
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sclk_i,
    input  logic                  sdat_i,
    input  logic                  slat_i,
    output logic                  word_vld_o,
    output logic [FRAME_BITS-1:0] word_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic                  sclk_p;
        logic                  lat_p;
        logic [FRAME_BITS-1:0] sr;
        logic [CNT_W-1:0]      cnt;
        logic                  vld;
        logic [FRAME_BITS-1:0] word;
    } st_t;

    st_t  st_d, st_q;
    logic sclk_rise, lat_rise;

    assign sclk_rise = sclk_i & ~st_q.sclk_p;
    assign lat_rise  = slat_i & ~st_q.lat_p;

    always_comb begin
        st_d        = st_q;
        st_d.sclk_p = sclk_i;
        st_d.lat_p  = slat_i;
        st_d.vld    = 1'b0;
        if (lat_rise) begin
            st_d.vld  = (st_q.cnt == CNT_FULL);
            st_d.word = st_q.sr;
            st_d.cnt  = '0;
        end else if (sclk_rise) begin
            st_d.sr  = {st_q.sr[FRAME_BITS-2:0], sdat_i};
            st_d.cnt = (st_q.cnt == CNT_SAT) ? CNT_SAT : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign word_vld_o = st_q.vld;
    assign word_o     = st_q.word;

    // R6
    cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lat_rise |=> st_q.cnt == '0);

    // R6
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_SAT);
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
    parameter int ADDR_W  = 4,
    parameter int RSV_W   = 2,
    parameter int DATA_W  = 10,
    parameter int NUM_VOL = 6,
    parameter int NUM_CTL = 3
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic                                     word_vld_i,
    input  logic [ADDR_W+RSV_W+DATA_W-1:0]           word_i,
    output logic [(NUM_VOL+NUM_CTL)*DATA_W-1:0]      regs_o
);
    localparam int FRAME_BITS = ADDR_W + RSV_W + DATA_W;
    localparam int NUM_REGS   = NUM_VOL + NUM_CTL;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_REGS - 1);

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] regs_t;

    typedef struct packed {
        regs_t regs;
    } st_t;

    function automatic regs_t reset_image();
        regs_t r;
        for (int i = 0; i < NUM_REGS; i++)
            r[i] = (i < NUM_VOL) ? {DATA_W{1'b1}} : '0;
        return r;
    endfunction

    st_t                st_d, st_q;
    logic [ADDR_W-1:0]  addr;
    logic [RSV_W-1:0]   rsv;
    logic [DATA_W-1:0]  data;
    logic               wr_ok;
    logic [NUM_REGS-1:0] chg;

    assign addr  = word_i[FRAME_BITS-1 -: ADDR_W];
    assign rsv   = word_i[DATA_W +: RSV_W];
    assign data  = word_i[DATA_W-1:0];
    assign wr_ok = word_vld_i && (rsv == '0) && (addr <= LAST_A);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_ok && addr == ADDR_W'(i))
                st_d.regs[i] = data;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q.regs <= reset_image();
        else         st_q      <= st_d;
    end

    assign regs_o = st_q.regs;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++)
            chg[i] = (st_d.regs[i] != st_q.regs[i]);
    end

    // R8
    hold_without_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !word_vld_i |=> $stable(st_q.regs));

    // R3
    rsv_bits_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld_i && rsv != '0) |=> $stable(st_q.regs));

    // R4
    bad_addr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld_i && addr > LAST_A) |=> $stable(st_q.regs));

    // R7
    one_reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(chg) <= 1);
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import ctl_port_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int RSV_W   = RSV_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int NUM_VOL = NUM_VOL_DEF,
    parameter int NUM_CTL = NUM_CTL_DEF
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        sclk_i,
    input  logic                        sdat_i,
    input  logic                        slat_i,
    output logic [NUM_VOL*DATA_W-1:0]   vol_o,
    output logic [NUM_CTL*DATA_W-1:0]   ctl_o
);
    localparam int FRAME_BITS = ADDR_W + RSV_W + DATA_W;
    localparam int NUM_REGS   = NUM_VOL + NUM_CTL;

    logic [2:0]                   pins_sync;
    logic                         word_vld;
    logic [FRAME_BITS-1:0]        word;
    logic [NUM_REGS*DATA_W-1:0]   regs;

    ctl_sync2 #(.WIDTH(3)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({slat_i, sdat_i, sclk_i}),
        .lvl_o   (pins_sync)
    );

    ctl_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sclk_i     (pins_sync[0]),
        .sdat_i     (pins_sync[1]),
        .slat_i     (pins_sync[2]),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    ctl_reg_bank #(
        .ADDR_W  (ADDR_W),
        .RSV_W   (RSV_W),
        .DATA_W  (DATA_W),
        .NUM_VOL (NUM_VOL),
        .NUM_CTL (NUM_CTL)
    ) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .word_vld_i (word_vld),
        .word_i     (word),
        .regs_o     (regs)
    );

    assign vol_o = regs[NUM_VOL*DATA_W-1:0];
    assign ctl_o = regs[NUM_REGS*DATA_W-1:NUM_VOL*DATA_W];
endmodule

// File: tb/ctl_serial_port_test.sv
module ctl_serial_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdat = 1'b0;
    logic        slat = 1'b0;
    logic [59:0] vol_o;
    logic [29:0] ctl_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [89:0] regs;
        string       tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [9:0]    model[9];

    always #10 clk = ~clk;

    ctl_serial_port uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .sclk_i (sclk),
        .sdat_i (sdat),
        .slat_i (slat),
        .vol_o  (vol_o),
        .ctl_o  (ctl_o)
    );

    function automatic logic [89:0] model_image();
        logic [89:0] r;
        for (int i = 0; i < 9; i++) r[i*10 +: 10] = model[i];
        return r;
    endfunction

    task automatic push_exp(input string tag);
        exp_t e;
        e.regs = model_image();
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive nbits of w, MSB first, then raise latch and queue expected state
    task automatic send(input logic [31:0] w, input int nbits, input string tag);
        for (int b = nbits - 1; b >= 0; b--) begin
            sdat = w[b];
            wait_clks(4);
            sclk = 1'b1;
            wait_clks(4);
            sclk = 1'b0;
        end
        wait_clks(4);
        if (nbits == 16 && w[11:10] == 2'b00 && w[15:12] <= 4'd8)
            model[w[15:12]] = w[9:0];
        slat = 1'b1;
        push_exp(tag);
        wait_clks(20);
        slat = 1'b0;
        wait_clks(4);
    endtask

    function automatic logic [15:0] mk(input logic [3:0] a, input logic [1:0] r, input logic [9:0] d);
        return {a, r, d};
    endfunction

    // Monitor: compare after the commit has settled
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            wait_clks(10);
            begin
                exp_t  e;
                logic [89:0] got;
                e   = exp_q.pop_front();
                got = {ctl_o, vol_o};
                n_run++;
                if (got !== e.regs) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", e.tag, got, e.regs);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 9; i++) model[i] = (i < 6) ? 10'h3FF : 10'h000;
        wait_clks(5);
        rst_n = 1'b1;
        push_exp("R5 reset values");
        wait_clks(20);

        send(mk(4'd0, 2'b00, 10'h123), 16, "R2 volume channel 0 write");
        send(mk(4'd5, 2'b00, 10'h155), 16, "R2 volume channel 5 write");
        send(mk(4'd8, 2'b00, 10'h2AA), 16, "R2 control word 2 write");
        send(mk(4'd6, 2'b00, 10'h3FF), 16, "R2 control word 0 write");
        send(mk(4'd3, 2'b00, 10'h001), 16, "R1 bit order low bit only");
        send(mk(4'd4, 2'b00, 10'h200), 16, "R1 bit order high bit only");
        send(mk(4'd9, 2'b00, 10'h000), 16, "R4 address 9 ignored");
        send(mk(4'd15, 2'b00, 10'h000), 16, "R4 address 15 ignored");
        send(mk(4'd1, 2'b10, 10'h000), 16, "R3 bit 11 set ignored");
        send(mk(4'd2, 2'b01, 10'h000), 16, "R3 bit 10 set ignored");
        send({17'h0, mk(4'd7, 2'b00, 10'h0F0)} >> 1, 15, "R6 short frame dropped");
        send(mk(4'd7, 2'b00, 10'h0F0), 16, "R6 good frame after short one");
        send({16'h0, mk(4'd1, 2'b00, 10'h000)}, 17, "R6 long frame dropped");
        send(mk(4'd1, 2'b00, 10'h0AA), 0, "R6 latch without clocks dropped");
        send(mk(4'd0, 2'b00, 10'h000), 16, "R7 overwrite channel 0 only");

        wait (exp_q.size() == 0);
        wait_clks(20);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule